// File: doc/BRIEF.md
# Flash Mode-Dependent Read Multiplexer

This block is the read side of a NOR flash model. A command decoder elsewhere reports which mode the flash is in; this block takes that mode, a byte address and an access size of one, two or four bytes, and returns the value a host would see. Depending on the mode, that value is array data, a manufacturer or device identification word, the operation status byte, or one byte of the common flash interface query table. The status byte lives here. The write side raises the erase-start, erase-done and program-done events that shape it, and each status read toggles one bit of it, so software polling can tell that an operation is still running.

The byte array is an inferred memory inside the block, filled through a simple byte load port. The query table arrives as a constant vector input. Read data is registered: a request in one cycle yields valid data in the next. If the mode code is not one the block knows, it still performs an array read and flags the decoder so that the decoder can fall back to read-array mode.

Top module: `flash_read_mux`

## Requirements
- R1: `rd_valid` is high in the cycle after each cycle with `rd_req` high and low otherwise; `rd_data` changes only in a cycle after a request.
- R2: In array mode (`mode`=0) and erase-setup mode (`mode`=1), a read with `BIG_ENDIAN`=0 returns byte `addr` in bits 7:0, `addr+1` in bits 15:8, `addr+2` in 23:16 and `addr+3` in 31:24. `rd_size` 0, 1 and 2 select 1, 2 and 4 bytes, and the unused upper bits read as zero.
- R3: With `BIG_ENDIAN`=1, a multi-byte array read puts the lowest-addressed byte in the most significant used byte: {addr, addr+1} for 2 bytes and {addr, ..., addr+3} for 4 bytes.
- R4: In autoselect mode (`mode`=2), the word offset is the low address byte divided by `BUS_BYTES`. Offset 0 returns `ID_W0`, offset 1 returns `ID_W1` and offset 2 returns 0, all zero-extended to 32 bits.
- R5: In autoselect mode, offsets 0x0E and 0x0F return `ID_W2` and `ID_W3`, unless the low byte of that word is 0xFF, in which case array data is returned. Every other offset returns array data.
- R6: In busy mode (`mode`=3), a read returns the status byte as it stood before the read. Bit 6 of the status byte is then inverted after each such read.
- R7: An `erase_start` pulse clears the status byte to 0x00. An `erase_done` pulse inverts status bit 7.
- R8: A `prog_done` pulse sets the status byte to {~`prog_msb`, 7'h7F}.
- R9: When events coincide, `erase_start` wins over `prog_done`, which wins over `erase_done`. Any event overrides the bit-6 toggle of a busy read in the same cycle.
- R10: In query mode (`mode`=4), a word offset below 82 returns table byte n, taken from `cfi_table[8n+7:8n]`. Larger offsets return 0.
- R11: Mode codes 5 to 7 read like array mode, and `mode_reset` is high together with that read's `rd_valid`. It is low otherwise.
- R12: After reset, `rd_valid`, `mode_reset` and `rd_data` are 0 and the status byte is 0x00.
- R13: `ld_en` writes `ld_byte` to array byte `ld_addr`, and later array reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Current command mode from the decoder |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address, aligned to the access size |
| rd_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes |
| ld_en | input | 1 | Array byte load strobe |
| ld_addr | input | ADDR_W | Array byte load address |
| ld_byte | input | 8 | Array byte load value |
| erase_start | input | 1 | Erase operation begins |
| erase_done | input | 1 | Erase operation ends |
| prog_done | input | 1 | Program operation performed |
| prog_msb | input | 1 | Bit 7 of the programmed data |
| cfi_table | input | 8*CFI_BYTES | Constant query table, byte n at bits 8n+7:8n |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| mode_reset | output | 1 | Unknown mode seen, decoder should return to read mode |

## Verification
The hardest case to reach is the status byte's history. Its value depends on every earlier busy read and on every event, including events that land in the same cycle as a read. Random stimulus therefore fires events with low probability alongside reads in all eight mode codes, and a bench model of the status byte tracks each edge. Directed sequences also force the three-way event collisions and the fallback from autoselect words whose low byte is 0xFF.

// File: rtl/flash_rd_pkg.sv
// Shared mode codes, size codes and event bundle for the flash read path.
package flash_rd_pkg;

    localparam logic [2:0] MODE_ARRAY       = 3'd0;
    localparam logic [2:0] MODE_ERASE_SETUP = 3'd1;
    localparam logic [2:0] MODE_AUTOSEL     = 3'd2;
    localparam logic [2:0] MODE_BUSY        = 3'd3;
    localparam logic [2:0] MODE_QUERY       = 3'd4;

    localparam logic [1:0] SIZE_1 = 2'd0;
    localparam logic [1:0] SIZE_2 = 2'd1;

    // Operation events delivered by the write side
    typedef struct packed {
        logic start;
        logic done;
        logic prog;
        logic prog_msb;
    } stat_evt_t;

endpackage

// File: rtl/flash_byte_array.sv
// Byte-wide storage with one load port and four combinational read lanes.
// Lane i returns the byte at rd_addr+i (address wraps at the array size).
// Assumes the caller keeps multi-byte accesses aligned.
module flash_byte_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_byte,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [LANES-1:0][7:0] lanes
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Load one byte when strobed
    always_ff @(posedge clk) begin
        if (ld_en) begin
            mem[ld_addr] <= ld_byte;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [ADDR_W-1:0] lane_addr;
        // Address of this lane's byte
        always_comb lane_addr = rd_addr + ADDR_W'(i);
        // Fetch this lane's byte
        always_comb lanes[i] = mem[lane_addr];
    end

endmodule

// File: rtl/flash_status_reg.sv
// Operation status byte. Events have fixed priority: start, program, done.
// A busy-mode read toggles bit 6 only in cycles without an event.
module flash_status_reg
    import flash_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  stat_evt_t  evt,
    input  logic       toggle_req,
    output logic [7:0] status_q
);
    // Status byte update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 8'h00;
        end else if (evt.start) begin
            status_q <= 8'h00;
        end else if (evt.prog) begin
            status_q <= {~evt.prog_msb, 7'h7F};
        end else if (evt.done) begin
            status_q <= status_q ^ 8'h80;
        end else if (toggle_req) begin
            status_q <= status_q ^ 8'h40;
        end
    end

endmodule

// File: rtl/flash_rd_select.sv
// Combinational source selection by mode: array assembly, identification,
// status and query table. Flags unknown mode codes, which read as array.
// Assumes aligned multi-byte accesses.
module flash_rd_select
    import flash_rd_pkg::*;
#(
    parameter int          BUS_BYTES  = 2,
    parameter bit          BIG_ENDIAN = 0,
    parameter int          CFI_BYTES  = 82,
    parameter logic [15:0] ID_W0      = 16'h0001,
    parameter logic [15:0] ID_W1      = 16'h0002,
    parameter logic [15:0] ID_W2      = 16'h0003,
    parameter logic [15:0] ID_W3      = 16'h00FF
) (
    input  logic [2:0]             mode,
    input  logic [7:0]             addr_lo,
    input  logic [1:0]             size,
    input  logic [3:0][7:0]        lanes,
    input  logic [7:0]             status,
    input  logic [CFI_BYTES*8-1:0] cfi_table,
    output logic [31:0]            data,
    output logic                   unknown
);
    localparam int SHIFT = (BUS_BYTES == 4) ? 2 : ((BUS_BYTES == 2) ? 1 : 0);

    logic [7:0]  woff;
    logic [31:0] arr_val;
    logic [31:0] id_val;
    logic [7:0]  cfi_val;
    logic [7:0]  cfi_b [CFI_BYTES];

    // Word offset from the low address byte
    always_comb woff = addr_lo >> SHIFT;

    for (genvar n = 0; n < CFI_BYTES; n++) begin : g_cfi
        // Split the table into bytes
        always_comb cfi_b[n] = cfi_table[8*n +: 8];
    end

    if (BIG_ENDIAN) begin : g_be
        // Lowest address in the most significant byte
        always_comb begin
            case (size)
                SIZE_1:  arr_val = {24'h0, lanes[0]};
                SIZE_2:  arr_val = {16'h0, lanes[0], lanes[1]};
                default: arr_val = {lanes[0], lanes[1], lanes[2], lanes[3]};
            endcase
        end
    end else begin : g_le
        // Lowest address in the least significant byte
        always_comb begin
            case (size)
                SIZE_1:  arr_val = {24'h0, lanes[0]};
                SIZE_2:  arr_val = {16'h0, lanes[1], lanes[0]};
                default: arr_val = {lanes[3], lanes[2], lanes[1], lanes[0]};
            endcase
        end
    end

    // Identification words, falling back to array data
    always_comb begin
        case (woff)
            8'h00:   id_val = {16'h0, ID_W0};
            8'h01:   id_val = {16'h0, ID_W1};
            8'h02:   id_val = 32'h0;
            8'h0E:   id_val = (ID_W2[7:0] == 8'hFF) ? arr_val : {16'h0, ID_W2};
            8'h0F:   id_val = (ID_W3[7:0] == 8'hFF) ? arr_val : {16'h0, ID_W3};
            default: id_val = arr_val;
        endcase
    end

    // Query table byte or zero past its end
    always_comb begin
        cfi_val = 8'h00;
        for (int n = 0; n < CFI_BYTES; n++) begin
            if (int'(woff) == n) cfi_val = cfi_b[n];
        end
    end

    // Final source choice by mode
    always_comb begin
        unknown = 1'b0;
        case (mode)
            MODE_ARRAY, MODE_ERASE_SETUP: data = arr_val;
            MODE_AUTOSEL:                 data = id_val;
            MODE_BUSY:                    data = {24'h0, status};
            MODE_QUERY:                   data = {24'h0, cfi_val};
            default: begin
                data    = arr_val;
                unknown = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/flash_read_mux.sv
// Top of the flash read path: storage, status byte, source selection and
// the output register. Data is valid one cycle after rd_req.
// Assumes aligned 2- and 4-byte accesses.
module flash_read_mux
    import flash_rd_pkg::*;
#(
    parameter int          ADDR_W     = 10,
    parameter int          BUS_BYTES  = 2,
    parameter bit          BIG_ENDIAN = 0,
    parameter int          CFI_BYTES  = 82,
    parameter logic [15:0] ID_W0      = 16'h0001,
    parameter logic [15:0] ID_W1      = 16'h0002,
    parameter logic [15:0] ID_W2      = 16'h0003,
    parameter logic [15:0] ID_W3      = 16'h00FF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             mode,
    input  logic                   rd_req,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [1:0]             rd_size,
    input  logic                   ld_en,
    input  logic [ADDR_W-1:0]      ld_addr,
    input  logic [7:0]             ld_byte,
    input  logic                   erase_start,
    input  logic                   erase_done,
    input  logic                   prog_done,
    input  logic                   prog_msb,
    input  logic [CFI_BYTES*8-1:0] cfi_table,
    output logic [31:0]            rd_data,
    output logic                   rd_valid,
    output logic                   mode_reset
);
    logic [3:0][7:0] lanes;
    logic [7:0]      status_q;
    logic [31:0]     sel_data;
    logic            sel_unknown;
    logic            toggle_req;
    stat_evt_t       evt;

    // Bundle the write-side events
    always_comb evt = '{start: erase_start, done: erase_done,
                        prog: prog_done, prog_msb: prog_msb};

    // A busy-mode read toggles bit 6
    always_comb toggle_req = rd_req && (mode == MODE_BUSY);

    flash_byte_array #(.ADDR_W(ADDR_W), .LANES(4)) u_array (
        .clk     (clk),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_byte (ld_byte),
        .rd_addr (rd_addr),
        .lanes   (lanes)
    );

    flash_status_reg u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .toggle_req (toggle_req),
        .status_q   (status_q)
    );

    flash_rd_select #(
        .BUS_BYTES  (BUS_BYTES),
        .BIG_ENDIAN (BIG_ENDIAN),
        .CFI_BYTES  (CFI_BYTES),
        .ID_W0      (ID_W0),
        .ID_W1      (ID_W1),
        .ID_W2      (ID_W2),
        .ID_W3      (ID_W3)
    ) u_select (
        .mode      (mode),
        .addr_lo   (rd_addr[7:0]),
        .size      (rd_size),
        .lanes     (lanes),
        .status    (status_q),
        .cfi_table (cfi_table),
        .data      (sel_data),
        .unknown   (sel_unknown)
    );

    // Output register: capture on request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data    <= 32'h0;
            rd_valid   <= 1'b0;
            mode_reset <= 1'b0;
        end else begin
            rd_valid   <= rd_req;
            mode_reset <= rd_req && sel_unknown;
            if (rd_req) begin
                rd_data <= sel_data;
            end
        end
    end

endmodule

// File: rtl/flash_read_mux_chk.sv
// Temporal checks on the flash read path, bound into every instance.
module flash_read_mux_chk #(
    parameter int ADDR_W    = 10,
    parameter int BUS_BYTES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              erase_start,
    input logic              erase_done,
    input logic              prog_done,
    input logic              prog_msb,
    input logic [7:0]        status_q,
    input logic [31:0]       rd_data,
    input logic              rd_valid,
    input logic              mode_reset
);
    localparam int SHIFT = (BUS_BYTES == 4) ? 2 : ((BUS_BYTES == 2) ? 1 : 0);

    logic any_evt;
    logic [7:0] woff;
    always_comb any_evt = erase_start || erase_done || prog_done;
    always_comb woff = rd_addr[7:0] >> SHIFT;

    // R1
    valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    // R1
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));
    // R6
    status_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && mode == 3'd3) |=> rd_data == {24'h0, $past(status_q)});
    // R6
    toggle_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && mode == 3'd3 && !any_evt) |=> status_q == ($past(status_q) ^ 8'h40));
    // R7
    erase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> status_q == 8'h00);
    // R8
    prog_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_done && !erase_start) |=> status_q == {~$past(prog_msb), 7'h7F});
    // R10
    query_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && mode == 3'd4 && woff >= 8'd82) |=> rd_data == 32'h0);
    // R11
    unknown_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && mode > 3'd4) |=> mode_reset);
    // R11
    flag_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_reset |-> rd_valid);

endmodule

bind flash_read_mux flash_read_mux_chk #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .erase_start (erase_start),
    .erase_done  (erase_done),
    .prog_done   (prog_done),
    .prog_msb    (prog_msb),
    .status_q    (status_q),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .mode_reset  (mode_reset)
);

// File: tb/sim_flash_read_mux.sv
// Bench: two instances (little-endian 16-bit bus, big-endian 8-bit bus)
// driven with identical stimulus and checked against a bench model.
module sim_flash_read_mux;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 10;
    localparam int DEP  = 1 << AW;
    localparam int CFIN = 82;
    localparam logic [15:0] I0 = 16'h0001;
    localparam logic [15:0] I1 = 16'h227E;
    localparam logic [15:0] I2 = 16'h2210;
    localparam logic [15:0] I3 = 16'h01FF;

    logic clk = 0;
    logic rst_n = 0;
    logic [2:0] mode = 0;
    logic rd_req = 0;
    logic [AW-1:0] rd_addr = 0;
    logic [1:0] rd_size = 0;
    logic ld_en = 0;
    logic [AW-1:0] ld_addr = 0;
    logic [7:0] ld_byte = 0;
    logic erase_start = 0, erase_done = 0, prog_done = 0, prog_msb = 0;
    logic [CFIN*8-1:0] cfi_v;
    logic [31:0] d0, d1;
    logic v0, v1, m0, m1;

    logic [7:0] mem_m [DEP];
    logic [7:0] cfi_m [CFIN];
    logic [7:0] status_m = 8'h00;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_read_mux #(.ADDR_W(AW), .BUS_BYTES(2), .BIG_ENDIAN(0), .CFI_BYTES(CFIN),
        .ID_W0(I0), .ID_W1(I1), .ID_W2(I2), .ID_W3(I3)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_size(rd_size), .ld_en(ld_en), .ld_addr(ld_addr), .ld_byte(ld_byte),
        .erase_start(erase_start), .erase_done(erase_done), .prog_done(prog_done),
        .prog_msb(prog_msb), .cfi_table(cfi_v), .rd_data(d0), .rd_valid(v0),
        .mode_reset(m0));

    flash_read_mux #(.ADDR_W(AW), .BUS_BYTES(1), .BIG_ENDIAN(1), .CFI_BYTES(CFIN),
        .ID_W0(I0), .ID_W1(I1), .ID_W2(I2), .ID_W3(I3)) u1 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_size(rd_size), .ld_en(ld_en), .ld_addr(ld_addr), .ld_byte(ld_byte),
        .erase_start(erase_start), .erase_done(erase_done), .prog_done(prog_done),
        .prog_msb(prog_msb), .cfi_table(cfi_v), .rd_data(d1), .rd_valid(v1),
        .mode_reset(m1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] arr_val(input bit be, input int a, input int sz);
        logic [7:0] b0, b1, b2, b3;
        b0 = mem_m[a % DEP]; b1 = mem_m[(a+1) % DEP];
        b2 = mem_m[(a+2) % DEP]; b3 = mem_m[(a+3) % DEP];
        if (sz == 0) return {24'h0, b0};
        if (sz == 1) return be ? {16'h0, b0, b1} : {16'h0, b1, b0};
        return be ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
    endfunction

    function automatic logic [31:0] exp_val(input bit be, input int sh, input int md,
                                            input int a, input int sz);
        int w;
        w = (a & 255) >> sh;
        case (md)
            2: begin
                if (w == 0) return {16'h0, I0};
                if (w == 1) return {16'h0, I1};
                if (w == 2) return 32'h0;
                if (w == 14) return (I2[7:0] == 8'hFF) ? arr_val(be, a, sz) : {16'h0, I2};
                if (w == 15) return (I3[7:0] == 8'hFF) ? arr_val(be, a, sz) : {16'h0, I3};
                return arr_val(be, a, sz);
            end
            3: return {24'h0, status_m};
            4: return (w < CFIN) ? {24'h0, cfi_m[w]} : 32'h0;
            default: return arr_val(be, a, sz);
        endcase
    endfunction

    function automatic string req_of(input int md);
        case (md)
            0, 1: return "R2/R3";
            2: return "R4/R5";
            3: return "R6";
            4: return "R10";
            default: return "R11";
        endcase
    endfunction

    // One cycle with optional read and events; checks both instances.
    task automatic cyc(input bit rq, input int md, input int a, input int sz,
                       input bit es, input bit ed, input bit pd, input bit pm,
                       input string tag);
        logic [31:0] e0, e1, h0, h1;
        h0 = d0; h1 = d1;
        e0 = exp_val(0, 1, md, a, sz);
        e1 = exp_val(1, 0, md, a, sz);
        rd_req = rq; mode = 3'(md); rd_addr = AW'(a); rd_size = 2'(sz);
        erase_start = es; erase_done = ed; prog_done = pd; prog_msb = pm;
        @(posedge clk);
        // status model, R9 priority
        if (es) status_m = 8'h00;
        else if (pd) status_m = {~pm, 7'h7F};
        else if (ed) status_m = status_m ^ 8'h80;
        else if (rq && md == 3) status_m = status_m ^ 8'h40;
        @(negedge clk);
        rd_req = 0; erase_start = 0; erase_done = 0; prog_done = 0;
        chk({"R1 valid ", tag}, {31'h0, v0 & v1}, {31'h0, rq});
        if (rq) begin
            chk({tag, " ", req_of(md), " le"}, d0, e0);
            chk({tag, " ", req_of(md), " be"}, d1, e1);
            chk({tag, " R11 flag"}, {31'h0, m0 | m1}, {31'h0, (md > 4) ? 1'b1 : 1'b0});
        end else begin
            chk({tag, " R1 hold"}, d0, h0);
            chk({tag, " R1 hold"}, d1, h1);
        end
    endtask

    task automatic load(input int a, input logic [7:0] b);
        ld_en = 1; ld_addr = AW'(a); ld_byte = b;
        @(negedge clk);
        ld_en = 0;
        mem_m[a] = b;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < CFIN; n++) begin
            cfi_m[n] = 8'(n * 7 + 3);
            cfi_v[8*n +: 8] = cfi_m[n];
        end
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 valid", {30'h0, v0, v1}, 32'h0);
        chk("R12 data", d0 | d1, 32'h0);
        chk("R12 flag", {30'h0, m0, m1}, 32'h0);
        rst_n = 1;
        for (int a = 0; a < DEP; a++) load(a, 8'($urandom));
        // R12 status starts at zero
        cyc(1, 3, 0, 0, 0, 0, 0, 0, "R12 status");
        // R13 load then read back
        load(12'h100 % DEP, 8'h5A);
        cyc(1, 0, 12'h100 % DEP, 0, 0, 0, 0, 0, "R13 readback");
        // R2 R3 sizes and erase-setup mode
        cyc(1, 0, 8, 1, 0, 0, 0, 0, "R2 R3 size2");
        cyc(1, 0, 16, 2, 0, 0, 0, 0, "R2 R3 size4");
        cyc(1, 1, 20, 2, 0, 0, 0, 0, "R2 erase setup");
        // R4 R5 autoselect offsets (u0 words are 2 bytes, u1 1 byte)
        for (int a = 0; a < 34; a++) cyc(1, 2, a, 0, 0, 0, 0, 0, "R4 R5 autosel");
        // R10 table edges
        cyc(1, 4, 81, 0, 0, 0, 0, 0, "R10 last");
        cyc(1, 4, 164, 0, 0, 0, 0, 0, "R10 past end");
        cyc(1, 4, 162, 0, 0, 0, 0, 0, "R10 edge");
        // R6 R7 R8 status sequences
        cyc(0, 0, 0, 0, 1, 0, 0, 0, "R7 start");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, "R6 poll a");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, "R6 poll b");
        cyc(0, 0, 0, 0, 0, 1, 0, 0, "R7 done");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, "R7 after done");
        cyc(0, 0, 0, 0, 0, 0, 1, 1, "R8 msb1");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, "R8 read msb1");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, "R8 msb0");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, "R8 read msb0");
        // R9 collisions
        cyc(1, 3, 0, 0, 1, 1, 1, 1, "R9 all");
        cyc(1, 3, 0, 0, 0, 1, 1, 0, "R9 prog over done");
        cyc(1, 3, 0, 0, 0, 1, 0, 0, "R9 done over toggle");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, "R9 observe");
        // R11 unknown codes
        cyc(1, 5, 40, 1, 0, 0, 0, 0, "R11 m5");
        cyc(1, 7, 44, 2, 0, 0, 0, 0, "R11 m7");
        // Random mix
        for (int i = 0; i < 600; i++) begin
            int md, sz, a;
            md = $urandom % 8;
            sz = $urandom % 3;
            a = ($urandom % 2) ? ($urandom % 256) : ($urandom % DEP);
            a = a & ~((1 << sz) - 1);
            cyc(($urandom % 5) != 0, md, a, sz, ($urandom % 16) == 0,
                ($urandom % 12) == 0, ($urandom % 12) == 0, 1'($urandom), "rand");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule